// File: doc/BRIEF.md
# Tap-Paced 32-bit Counter with Overflow

This block counts time in coarse units derived from a fast reference clock. A free-running prescaler advances once per clock cycle while the block is enabled. Software picks one bit of that prescaler, and every rising transition of the chosen bit moves a 32-bit counter forward by one. A tap at bit index `k` therefore advances the counter at the clock rate divided by 2^(k+1).

The counter can be loaded at any time through its write port, and its value is always visible on the read port. When the counter rolls over from all ones to zero, a sticky overflow flag is raised, and software clears it by writing a one to its clear input. An optional alarm-reset mode returns the counter to zero when it reaches a compare value, and that event also raises the flag. A calendar-mode bit stops a plain rollover from raising the flag. The calendar field counting itself is not part of this block.

The prescaler has no read or write path. Software can only zero it, and it holds its value while the block is disabled.

Top module: `tap_paced_counter`

## Requirements
- R1: After reset, `cv_rd_data` is 0 and `ovf_flag` is 0.
- R2: While `en` is 0, the prescaler, the stored previous tap level and the counter all hold their values. Counting resumes on re-enable as if no cycles had passed.
- R3: A cycle with `presc_clr` at 1 leaves the prescaler at zero, even while enabled. Clearing takes priority over incrementing.
- R4: While `en` is 1, the prescaler advances by one per clock. The counter advances by one on each 0-to-1 transition of prescaler bit `tap_sel`, so bit `k` gives one count per 2^(k+1) clocks.
- R5: In the cycle where `tap_sel` takes a new value, no count is produced, even when the newly chosen bit reads 1 and the previously stored level was 0.
- R6: With `cal_mode` at 0, a count taken from 0xFFFFFFFF gives 0x00000000 and sets `ovf_flag` to 1.
- R7: With `cal_mode` at 1, a count taken from 0xFFFFFFFF still gives 0 but leaves `ovf_flag` unchanged.
- R8: With `alarm_rst_en` at 1, a count taken while the counter equals `alarm_value` loads 0 and sets `ovf_flag`. With `alarm_rst_en` at 0, the same count just increments.
- R9: When `cv_wr_en` is 1, the next counter value is `cv_wr_data`, even if a count falls in the same cycle.
- R10: `ovf_flag` stays at 1 until a cycle with `ovf_clr` at 1 clears it. If an overflow event and `ovf_clr` fall in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables the prescaler and counting |
| presc_clr | input | 1 | Zeroes the prescaler |
| tap_sel | input | 5 | Index of the prescaler bit that paces the counter |
| cal_mode | input | 1 | When 1, a rollover does not raise the flag |
| alarm_rst_en | input | 1 | Enables the zero-on-compare behaviour |
| alarm_value | input | 32 | Compare value for the alarm reset |
| cv_wr_en | input | 1 | Loads the counter from `cv_wr_data` |
| cv_wr_data | input | 32 | Counter load value |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| cv_rd_data | output | 32 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The pacing function is driven with taps 0 through 5 over run lengths from one clock to two hundred. The long runs show that the rate halves with each step up in tap index. The short runs show the phase, meaning whether the first count lands on the first rising transition of the chosen bit or one cycle off it. Loads of 0xFFFFFFFF and of the compare value are placed exactly on a counting cycle. This separates write priority from increment, plain rollover from alarm zeroing, and the flag behaviour in calendar and counter modes. Pausing, clearing the prescaler and switching taps mid-run show whether the stored edge history is frozen, zeroed or resynchronized.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_STEP = 2'd2,
    CNT_ZERO = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/tpc_prescaler.sv
module tpc_prescaler #(
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  output logic [PRE_W-1:0] value
);

  localparam logic [PRE_W-1:0] ONE = 1;

  logic [PRE_W-1:0] value_d;

  always_comb begin
    value_d = value;
    if (clr) begin
      value_d = '0;
    end else if (en) begin
      value_d = value + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else begin
      value <= value_d;
    end
  end

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (value == '0));

  p_frozen_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(value));

endmodule

// File: rtl/tpc_tap_edge.sv
module tpc_tap_edge #(
  parameter int PRE_W = 32,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] pre,
  input  logic [SEL_W-1:0] sel,
  output logic             rise
);

  logic             tap_now;
  logic             prev_q;
  logic             prev_d;
  logic [SEL_W-1:0] sel_q;
  logic             sel_moved;

  always_comb begin
    tap_now   = pre[sel];
    sel_moved = (sel != sel_q);
    prev_d    = prev_q;
    if (sel_moved || en) begin
      prev_d = tap_now;
    end
    rise = en && !sel_moved && tap_now && !prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      prev_q <= prev_d;
      sel_q  <= sel;
    end
  end

  p_quiet_on_sel_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> !rise);

  p_no_rise_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !rise);

endmodule

// File: rtl/tpc_count_core.sv
module tpc_count_core
  import tpc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cal_mode,
  input  logic             alarm_rst,
  input  logic [CNT_W-1:0] alarm_value,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] ONE = 1;

  cnt_op_e          op;
  logic [CNT_W-1:0] count_d;
  logic             ovf_d;
  logic             at_top;
  logic             alarm_hit;
  logic             ovf_set;

  always_comb begin
    at_top    = &count;
    alarm_hit = alarm_rst && (count == alarm_value);
    if (wr_en) begin
      op = CNT_LOAD;
    end else if (tick) begin
      op = alarm_hit ? CNT_ZERO : CNT_STEP;
    end else begin
      op = CNT_HOLD;
    end
    case (op)
      CNT_LOAD: count_d = wr_data;
      CNT_STEP: count_d = count + ONE;
      CNT_ZERO: count_d = '0;
      default:  count_d = count;
    endcase
    ovf_set = tick && !wr_en && (alarm_hit || (at_top && !cal_mode));
    if (ovf_set) begin
      ovf_d = 1'b1;
    end else if (ovf_clr) begin
      ovf_d = 1'b0;
    end else begin
      ovf_d = ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= count_d;
      ovf   <= ovf_d;
    end
  end

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_data)));

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && !alarm_hit) |=> (count == $past(count) + ONE));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(count));

  p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && at_top && !cal_mode) |=> (ovf && count == '0));

  p_cal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && tick && !wr_en && at_top && cal_mode && !alarm_hit) |=> !ovf);

  p_alarm_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && alarm_hit) |=> (ovf && count == '0));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

endmodule

// File: rtl/tap_paced_counter.sv
module tap_paced_counter #(
  parameter  int PRE_W = 32,
  parameter  int CNT_W = 32,
  localparam int SEL_W = $clog2(PRE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             presc_clr,
  input  logic [SEL_W-1:0] tap_sel,
  input  logic             cal_mode,
  input  logic             alarm_rst_en,
  input  logic [CNT_W-1:0] alarm_value,
  input  logic             cv_wr_en,
  input  logic [CNT_W-1:0] cv_wr_data,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cv_rd_data,
  output logic             ovf_flag
);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [PRE_W-1:0] pre_value;
  logic             tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[1];

  tpc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (en),
    .clr   (presc_clr),
    .value (pre_value)
  );

  tpc_tap_edge #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (en),
    .pre   (pre_value),
    .sel   (tap_sel),
    .rise  (tick)
  );

  tpc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick        (tick),
    .wr_en       (cv_wr_en),
    .wr_data     (cv_wr_data),
    .cal_mode    (cal_mode),
    .alarm_rst   (alarm_rst_en),
    .alarm_value (alarm_value),
    .ovf_clr     (ovf_clr),
    .count       (cv_rd_data),
    .ovf         (ovf_flag)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_sync_n |=> (!rst_sync_n || (cv_rd_data == '0 && !ovf_flag)));

endmodule

// File: tb/tap_paced_counter_bench.sv
`timescale 1ns/1ps
module tap_paced_counter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        presc_clr;
  logic [4:0]  tap_sel;
  logic        cal_mode;
  logic        alarm_rst_en;
  logic [31:0] alarm_value;
  logic        cv_wr_en;
  logic [31:0] cv_wr_data;
  logic        ovf_clr;
  logic [31:0] cv_rd_data;
  logic        ovf_flag;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  tap_paced_counter u_tap_paced_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .presc_clr    (presc_clr),
    .tap_sel      (tap_sel),
    .cal_mode     (cal_mode),
    .alarm_rst_en (alarm_rst_en),
    .alarm_value  (alarm_value),
    .cv_wr_en     (cv_wr_en),
    .cv_wr_data   (cv_wr_data),
    .ovf_clr      (ovf_clr),
    .cv_rd_data   (cv_rd_data),
    .ovf_flag     (ovf_flag)
  );

  // Pacing vectors (R4): tap, enabled clocks, expected count = floor((C-1+2^k)/2^(k+1))
  localparam int NV = 8;
  localparam int V_TAP [0:NV-1] = '{0, 1, 2, 3, 4, 0, 1, 5};
  localparam int V_CYC [0:NV-1] = '{10, 10, 20, 50, 100, 1, 3, 200};
  localparam int V_EXP [0:NV-1] = '{5, 2, 2, 3, 3, 0, 1, 3};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Zero prescaler and counter, clear the flag, pick tap; leaves en=1 before clock 1
  task automatic arm(input logic [4:0] k);
    en = 1'b0; presc_clr = 1'b1; cv_wr_en = 1'b1; cv_wr_data = '0;
    ovf_clr = 1'b1; tap_sel = k;
    step();
    presc_clr = 1'b0; cv_wr_en = 1'b0; ovf_clr = 1'b0; en = 1'b1;
  endtask

  // Load a value exactly on a counting clock of tap 0, then run to the next count
  task automatic load_then_count(input logic [31:0] v, input logic clr_at_count);
    arm(5'd0);
    step();
    cv_wr_en = 1'b1; cv_wr_data = v;
    step();
    cv_wr_en = 1'b0;
    chk("R9 load on counting clock", cv_rd_data, v);
    step();
    ovf_clr = clr_at_count;
    step();
    ovf_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; presc_clr = 1'b0; tap_sel = '0; cal_mode = 1'b0;
    alarm_rst_en = 1'b0; alarm_value = '0; cv_wr_en = 1'b0; cv_wr_data = '0; ovf_clr = 1'b0;
    repeat (3) step();
    chk("R1 reset counter", cv_rd_data, 32'h0);
    chk("R1 reset flag", {31'b0, ovf_flag}, 32'h0);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 after release", cv_rd_data, 32'h0);

    // R4 pacing table
    for (int i = 0; i < NV; i++) begin
      arm(V_TAP[i][4:0]);
      repeat (V_CYC[i]) step();
      en = 1'b0;
      chk($sformatf("R4 tap %0d over %0d clocks", V_TAP[i], V_CYC[i]), cv_rd_data, V_EXP[i]);
    end

    // R2: pause mid-run, nothing moves, then resume with the pending edge kept
    arm(5'd1);
    repeat (2) step();
    en = 1'b0;
    repeat (10) step();
    chk("R2 hold while disabled", cv_rd_data, 32'h0);
    en = 1'b1;
    repeat (2) step();
    chk("R2 resume keeps prescaler", cv_rd_data, 32'h1);

    // R3: clear held while enabled keeps the prescaler at zero
    arm(5'd1);
    presc_clr = 1'b1;
    repeat (12) step();
    presc_clr = 1'b0;
    chk("R3 clear blocks counting", cv_rd_data, 32'h0);
    repeat (3) step();
    chk("R3 restart from zero", cv_rd_data, 32'h1);

    // R5: switch to a tap reading 1 while stored level is 0
    arm(5'd0);
    repeat (3) step();
    chk("R5 before switch", cv_rd_data, 32'h1);
    tap_sel = 5'd1;
    repeat (2) step();
    chk("R5 no false count", cv_rd_data, 32'h1);

    // R9: load on counting clock, then next count increments the loaded value
    load_then_count(32'h1234_5678, 1'b0);
    chk("R9 count after load", cv_rd_data, 32'h1234_5679);

    // R6: rollover sets the flag
    load_then_count(32'hFFFF_FFFF, 1'b0);
    chk("R6 wrap to zero", cv_rd_data, 32'h0);
    chk("R6 flag set", {31'b0, ovf_flag}, 32'h1);

    // R10: flag held, collision keeps it, lone clear drops it
    en = 1'b0;
    repeat (5) step();
    chk("R10 flag sticky", {31'b0, ovf_flag}, 32'h1);
    load_then_count(32'hFFFF_FFFF, 1'b1);
    chk("R10 set beats clear", {31'b0, ovf_flag}, 32'h1);
    en = 1'b0; ovf_clr = 1'b1;
    step();
    ovf_clr = 1'b0;
    chk("R10 clear drops flag", {31'b0, ovf_flag}, 32'h0);

    // R7: calendar mode rollover leaves the flag
    cal_mode = 1'b1;
    load_then_count(32'hFFFF_FFFF, 1'b0);
    chk("R7 wrap value", cv_rd_data, 32'h0);
    chk("R7 flag untouched", {31'b0, ovf_flag}, 32'h0);
    cal_mode = 1'b0;

    // R8: alarm reset on and off
    alarm_value = 32'd5;
    alarm_rst_en = 1'b1;
    load_then_count(32'd5, 1'b0);
    chk("R8 alarm zeroes", cv_rd_data, 32'h0);
    chk("R8 alarm flag", {31'b0, ovf_flag}, 32'h1);
    alarm_rst_en = 1'b0;
    load_then_count(32'd5, 1'b0);
    chk("R8 alarm off increments", cv_rd_data, 32'd6);
    chk("R8 alarm off no flag", {31'b0, ovf_flag}, 32'h0);

    en = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule